// File: doc/BRIEF.md
# Inter-warp line-request merging pool

This block sits between the per-warp coalescers of a throughput processor's load path and the L1 cache. Each input delivers requests for one cache line at a time. A request carries the line address, the ID of the issuing warp, and a lane mask that marks which of the warp's threads want data from that line. When warps read neighbouring data, several of them often ask for the same line within a short window. The block gathers those requests into one pending entry per line, so the L1 sees a single access that serves up to four warps.

Each request goes to one of several small queues, chosen by the low bits of its line address. Inside that queue a tag compare decides between two cases. If the line is already pending with spare sharer capacity, the request joins that entry. Otherwise it takes a free tag slot and gets an age stamp. Only one insertion per queue is accepted in a cycle. The output side offers the oldest pending entry on a valid/ready stream. The handshake frees that entry and returns its full sharer list, so replies can be routed back to every waiting warp.

Back-pressure rules follow the stream rules. An input request holds its payload while `in_valid` is high and `in_ready` is low. `in_ready` is computed in the same cycle from the valid inputs and the queue state, and it is never high while `in_valid` is low. On the output side, the presented line stays fixed while `out_valid` is high and `out_ready` is low. The sharer list of that entry may still grow during the stall.

Top module: `xwarp_merge_pool`

## Requirements
- R1: During reset and right after it, no entry is pending: `out_valid` is low and every `in_ready` is low.
- R2: A request is steered to queue number `line mod N_Q`, which is the low log2(N_Q) address bits. Requests whose lines differ in those bits never compete for a queue.
- R3: A request that misses in its queue while a tag slot is free creates an entry with count 1. Sharer slot 0 (the lowest `WARP_W` bits of `out_warps` and the lowest `LANES` bits of `out_masks`) holds its warp and mask, and the unused sharer slots read as zero.
- R4: A request that hits a pending entry of the same line with fewer than `MAX_SHR` sharers is appended in the next sharer slot. Slots fill in arrival order and the count rises by one. `out_count` of a valid entry always lies between 1 and `MAX_SHR`.
- R5: A request for a line whose pending entry already holds `MAX_SHR` sharers is placed in a new entry.
- R6: When several valid inputs target the same queue in one cycle, only the lowest-numbered one can be accepted. The others see `in_ready` low.
- R7: Valid inputs that target different queues can all be accepted in the same cycle.
- R8: A request whose queue has no free slot and no matching entry with spare capacity is stalled (`in_ready` low) until a slot of that queue is freed.
- R9: The output presents the pending entry with the greatest age. Entries of equal age are ordered by entry index (queue number × `N_TAG` + slot), and the lower index goes first.
- R10: An entry is removed in the cycle `out_valid` and `out_ready` are both high. While the output is stalled, `out_valid` stays high and `out_line` does not change.
- R11: In a cycle in which an entry of queue q is granted, no request to queue q is accepted.
- R12: `in_ready` is never high for an input whose `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_IN | Request valid, one bit per input |
| in_ready | output | N_IN | Request accepted this cycle, one bit per input |
| in_line | input | N_IN*LINE_W | Cache-line address per input |
| in_warp | input | N_IN*WARP_W | Warp ID per input |
| in_mask | input | N_IN*LANES | Lane mask per input |
| out_valid | output | 1 | A pending line is offered |
| out_ready | input | 1 | Selection stage takes the offered line |
| out_line | output | LINE_W | Offered cache-line address |
| out_count | output | $clog2(MAX_SHR+1) | Number of sharers in the offered entry |
| out_warps | output | MAX_SHR*WARP_W | Sharer warp IDs, slot 0 in the low bits |
| out_masks | output | MAX_SHR*LANES | Sharer lane masks, slot 0 in the low bits |

## Verification
`in_ready` is a same-cycle function of the valid inputs, the queue state and the output grant. The bench therefore drives stimulus just after a falling edge and samples ready one time step later, before the rising edge that would accept it. The queue state changes only at the rising edge, and the output stream is a combinational view of that state. A merge, an allocation or a removal is therefore checked at the falling edge that follows the accepting rising edge, which is one cycle after the stimulus and before new inputs are applied. Stall, conflict, capacity and age-order cases are each driven so that exactly one such edge separates cause and check.

// File: rtl/xwm_pkg.sv
package xwm_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_MERGE = 2'd1,
    ACT_ALLOC = 2'd2
  } ins_act_e;
endpackage

// File: rtl/xwm_steer.sv
module xwm_steer #(
  parameter int N_IN   = 2,
  parameter int N_Q    = 32,
  parameter int LINE_W = 26,
  localparam int QW    = $clog2(N_Q),
  localparam int IW    = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]        in_valid,
  input  logic [N_IN*LINE_W-1:0] in_line,
  output logic [N_IN*QW-1:0]     in_q,
  output logic [N_Q-1:0]         win_vld,
  output logic [N_Q*IW-1:0]      win_idx
);
  always_comb begin
    for (int i = 0; i < N_IN; i++) in_q[i*QW +: QW] = in_line[i*LINE_W +: QW];
  end

  // lowest-numbered valid input per queue wins (scan high to low)
  always_comb begin
    win_vld = '0;
    win_idx = '0;
    for (int q = 0; q < N_Q; q++) begin
      for (int i = N_IN-1; i >= 0; i--) begin
        if (in_valid[i] && in_line[i*LINE_W +: QW] == QW'(q)) begin
          win_vld[q]            = 1'b1;
          win_idx[q*IW +: IW]   = IW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/xwm_queue.sv
module xwm_queue import xwm_pkg::*; #(
  parameter int LINE_W  = 26,
  parameter int WARP_W  = 6,
  parameter int LANES   = 32,
  parameter int N_TAG   = 4,
  parameter int MAX_SHR = 4,
  parameter int STAMP_W = 16,
  localparam int TW     = $clog2(N_TAG),
  localparam int CW     = $clog2(MAX_SHR+1),
  localparam int SW     = $clog2(MAX_SHR),
  localparam int SHW    = MAX_SHR*WARP_W,
  localparam int SHM    = MAX_SHR*LANES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_fire,
  input  logic [LINE_W-1:0]        req_line,
  input  logic [WARP_W-1:0]        req_warp,
  input  logic [LANES-1:0]         req_mask,
  input  logic [STAMP_W-1:0]       now,
  input  logic                     pop,
  input  logic [TW-1:0]            pop_slot,
  output logic                     can_take,
  output logic [N_TAG-1:0]         slot_vld,
  output logic [N_TAG*LINE_W-1:0]  slot_line,
  output logic [N_TAG*CW-1:0]      slot_cnt,
  output logic [N_TAG*STAMP_W-1:0] slot_stamp,
  output logic [N_TAG*SHW-1:0]     slot_warps,
  output logic [N_TAG*SHM-1:0]     slot_masks
);
  logic [N_TAG-1:0]   vld_q;
  logic [LINE_W-1:0]  line_q  [N_TAG];
  logic [CW-1:0]      cnt_q   [N_TAG];
  logic [STAMP_W-1:0] stamp_q [N_TAG];
  logic [SHW-1:0]     warps_q [N_TAG];
  logic [SHM-1:0]     masks_q [N_TAG];

  logic          hit, free_any;
  logic [TW-1:0] hit_t, free_t;
  logic [SW-1:0] hit_sh;
  ins_act_e      act;

  always_comb begin
    hit = 1'b0; hit_t = '0; free_any = 1'b0; free_t = '0;
    for (int t = N_TAG-1; t >= 0; t--) begin
      if (vld_q[t] && line_q[t] == req_line && cnt_q[t] < CW'(MAX_SHR)) begin
        hit = 1'b1; hit_t = TW'(t);
      end
      if (!vld_q[t]) begin
        free_any = 1'b1; free_t = TW'(t);
      end
    end
    hit_sh   = cnt_q[hit_t][SW-1:0];
    can_take = hit | free_any;
    if (!req_fire)     act = ACT_IDLE;
    else if (hit)      act = ACT_MERGE;
    else if (free_any) act = ACT_ALLOC;
    else               act = ACT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int t = 0; t < N_TAG; t++) begin
        line_q[t] <= '0; cnt_q[t] <= '0; stamp_q[t] <= '0;
        warps_q[t] <= '0; masks_q[t] <= '0;
      end
    end else begin
      if (pop) vld_q[pop_slot] <= 1'b0;
      case (act)
        ACT_MERGE: begin
          warps_q[hit_t][hit_sh*WARP_W +: WARP_W] <= req_warp;
          masks_q[hit_t][hit_sh*LANES +: LANES]   <= req_mask;
          cnt_q[hit_t] <= cnt_q[hit_t] + CW'(1);
        end
        ACT_ALLOC: begin
          vld_q[free_t]   <= 1'b1;
          line_q[free_t]  <= req_line;
          cnt_q[free_t]   <= CW'(1);
          stamp_q[free_t] <= now;
          warps_q[free_t] <= SHW'(req_warp);
          masks_q[free_t] <= SHM'(req_mask);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    slot_vld = vld_q;
    for (int t = 0; t < N_TAG; t++) begin
      slot_line[t*LINE_W +: LINE_W]    = line_q[t];
      slot_cnt[t*CW +: CW]             = cnt_q[t];
      slot_stamp[t*STAMP_W +: STAMP_W] = stamp_q[t];
      slot_warps[t*SHW +: SHW]         = warps_q[t];
      slot_masks[t*SHM +: SHM]         = masks_q[t];
    end
  end
endmodule

// File: rtl/xwm_oldest.sv
module xwm_oldest #(
  parameter int N_ENT   = 128,
  parameter int STAMP_W = 16,
  localparam int EW     = $clog2(N_ENT)
) (
  input  logic [STAMP_W-1:0]       now,
  input  logic [N_ENT-1:0]         ent_vld,
  input  logic [N_ENT*STAMP_W-1:0] ent_stamp,
  output logic                     sel_vld,
  output logic [EW-1:0]            sel_idx
);
  logic [STAMP_W-1:0] age, best;

  // greatest age wins; strict compare keeps the lower index on ties
  always_comb begin
    sel_vld = 1'b0; sel_idx = '0; best = '0; age = '0;
    for (int e = 0; e < N_ENT; e++) begin
      age = now - ent_stamp[e*STAMP_W +: STAMP_W];
      if (ent_vld[e] && (!sel_vld || age > best)) begin
        sel_vld = 1'b1; sel_idx = EW'(e); best = age;
      end
    end
  end
endmodule

// File: rtl/xwarp_merge_pool.sv
module xwarp_merge_pool import xwm_pkg::*; #(
  parameter int N_IN    = 2,
  parameter int N_Q     = 32,
  parameter int N_TAG   = 4,
  parameter int MAX_SHR = 4,
  parameter int LINE_W  = 26,
  parameter int WARP_W  = 6,
  parameter int LANES   = 32,
  parameter int STAMP_W = 16,
  localparam int QW     = $clog2(N_Q),
  localparam int IW     = $clog2(N_IN),
  localparam int TW     = $clog2(N_TAG),
  localparam int CW     = $clog2(MAX_SHR+1),
  localparam int N_ENT  = N_Q*N_TAG,
  localparam int EW     = $clog2(N_ENT),
  localparam int SHW    = MAX_SHR*WARP_W,
  localparam int SHM    = MAX_SHR*LANES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          in_valid,
  output logic [N_IN-1:0]          in_ready,
  input  logic [N_IN*LINE_W-1:0]   in_line,
  input  logic [N_IN*WARP_W-1:0]   in_warp,
  input  logic [N_IN*LANES-1:0]    in_mask,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LINE_W-1:0]        out_line,
  output logic [CW-1:0]            out_count,
  output logic [SHW-1:0]           out_warps,
  output logic [SHM-1:0]           out_masks
);
  logic [STAMP_W-1:0] now_q;
  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + STAMP_W'(1);
  end

  logic [N_IN*QW-1:0] in_q;
  logic [N_Q-1:0]     win_vld;
  logic [N_Q*IW-1:0]  win_idx;

  xwm_steer #(.N_IN(N_IN), .N_Q(N_Q), .LINE_W(LINE_W)) u_steer (
    .in_valid(in_valid), .in_line(in_line),
    .in_q(in_q), .win_vld(win_vld), .win_idx(win_idx)
  );

  logic [N_ENT-1:0]         ent_vld;
  logic [N_ENT*STAMP_W-1:0] ent_stamp;
  logic [LINE_W-1:0]        ent_line  [N_ENT];
  logic [CW-1:0]            ent_cnt   [N_ENT];
  logic [SHW-1:0]           ent_warps [N_ENT];
  logic [SHM-1:0]           ent_masks [N_ENT];
  logic                     sel_vld;
  logic [EW-1:0]            sel_idx;

  xwm_oldest #(.N_ENT(N_ENT), .STAMP_W(STAMP_W)) u_pick (
    .now(now_q), .ent_vld(ent_vld), .ent_stamp(ent_stamp),
    .sel_vld(sel_vld), .sel_idx(sel_idx)
  );

  logic          out_fire;
  logic [QW-1:0] sel_q;
  logic [TW-1:0] sel_t;
  assign out_fire = sel_vld & out_ready;
  assign sel_q    = sel_idx[EW-1:TW];
  assign sel_t    = sel_idx[TW-1:0];

  logic [N_Q-1:0] q_take, q_pop, q_fire;
  logic [N_TAG-1:0]         qs_vld   [N_Q];
  logic [N_TAG*LINE_W-1:0]  qs_line  [N_Q];
  logic [N_TAG*CW-1:0]      qs_cnt   [N_Q];
  logic [N_TAG*STAMP_W-1:0] qs_stamp [N_Q];
  logic [N_TAG*SHW-1:0]     qs_warps [N_Q];
  logic [N_TAG*SHM-1:0]     qs_masks [N_Q];

  for (genvar q = 0; q < N_Q; q++) begin : g_q
    logic [IW-1:0] wi;
    assign wi        = win_idx[q*IW +: IW];
    assign q_pop[q]  = out_fire && sel_q == QW'(q);
    assign q_fire[q] = win_vld[q] && q_take[q] && !q_pop[q];

    xwm_queue #(
      .LINE_W(LINE_W), .WARP_W(WARP_W), .LANES(LANES),
      .N_TAG(N_TAG), .MAX_SHR(MAX_SHR), .STAMP_W(STAMP_W)
    ) u_q (
      .clk(clk), .rst_n(rst_n),
      .req_fire(q_fire[q]),
      .req_line(in_line[wi*LINE_W +: LINE_W]),
      .req_warp(in_warp[wi*WARP_W +: WARP_W]),
      .req_mask(in_mask[wi*LANES +: LANES]),
      .now(now_q), .pop(q_pop[q]), .pop_slot(sel_t),
      .can_take(q_take[q]),
      .slot_vld(qs_vld[q]), .slot_line(qs_line[q]), .slot_cnt(qs_cnt[q]),
      .slot_stamp(qs_stamp[q]), .slot_warps(qs_warps[q]), .slot_masks(qs_masks[q])
    );

    for (genvar t = 0; t < N_TAG; t++) begin : g_t
      assign ent_vld[q*N_TAG+t]                        = qs_vld[q][t];
      assign ent_stamp[(q*N_TAG+t)*STAMP_W +: STAMP_W] = qs_stamp[q][t*STAMP_W +: STAMP_W];
      assign ent_line[q*N_TAG+t]  = qs_line[q][t*LINE_W +: LINE_W];
      assign ent_cnt[q*N_TAG+t]   = qs_cnt[q][t*CW +: CW];
      assign ent_warps[q*N_TAG+t] = qs_warps[q][t*SHW +: SHW];
      assign ent_masks[q*N_TAG+t] = qs_masks[q][t*SHM +: SHM];
    end
  end

  logic [QW-1:0] iq;
  always_comb begin
    iq = '0;
    for (int i = 0; i < N_IN; i++) begin
      iq = in_q[i*QW +: QW];
      in_ready[i] = in_valid[i] && win_vld[iq] && win_idx[iq*IW +: IW] == IW'(i)
                    && q_take[iq] && !q_pop[iq];
    end
  end

  assign out_valid = sel_vld;
  assign out_line  = sel_vld ? ent_line[sel_idx]  : '0;
  assign out_count = sel_vld ? ent_cnt[sel_idx]   : '0;
  assign out_warps = sel_vld ? ent_warps[sel_idx] : '0;
  assign out_masks = sel_vld ? ent_masks[sel_idx] : '0;
endmodule

// File: rtl/xwm_check.sv
module xwm_check #(
  parameter int N_IN    = 2,
  parameter int N_Q     = 32,
  parameter int LINE_W  = 26,
  parameter int MAX_SHR = 4,
  localparam int QW     = $clog2(N_Q),
  localparam int CW     = $clog2(MAX_SHR+1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_IN-1:0]        in_valid,
  input logic [N_IN-1:0]        in_ready,
  input logic [N_IN*LINE_W-1:0] in_line,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LINE_W-1:0]      out_line,
  input logic [CW-1:0]          out_count
);
  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_ready_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);

  assert_one_per_queue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid[0] && in_valid[1] && in_line[QW-1:0] == in_line[LINE_W +: QW]) |-> !in_ready[1]);

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count >= CW'(1) && out_count <= CW'(MAX_SHR)));

  assert_hold_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_line)));
endmodule

bind xwarp_merge_pool xwm_check #(
  .N_IN(N_IN), .N_Q(N_Q), .LINE_W(LINE_W), .MAX_SHR(MAX_SHR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_line(in_line), .out_valid(out_valid), .out_ready(out_ready),
  .out_line(out_line), .out_count(out_count)
);

// File: tb/tb_xwarp_merge_pool.sv
module tb_xwarp_merge_pool;
  localparam int LW = 26, WW = 6, LN = 32, MS = 4, CW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic [1:0]        in_valid;
  logic [1:0]        in_ready;
  logic [2*LW-1:0]   in_line;
  logic [2*WW-1:0]   in_warp;
  logic [2*LN-1:0]   in_mask;
  logic              out_ready, out_valid;
  logic [LW-1:0]     out_line;
  logic [CW-1:0]     out_count;
  logic [MS*WW-1:0]  out_warps;
  logic [MS*LN-1:0]  out_masks;

  xwarp_merge_pool dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_line(in_line), .in_warp(in_warp), .in_mask(in_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line),
    .out_count(out_count), .out_warps(out_warps), .out_masks(out_masks)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LN-1:0] mk(logic [WW-1:0] w);
    return 32'h1 << w[4:0];
  endfunction

  task automatic drive(bit v0, logic [7:0] l0, logic [5:0] w0,
                       bit v1, logic [7:0] l1, logic [5:0] w1, bit ordy);
    in_valid  = {v1, v0};
    in_line   = {LW'(l1), LW'(l0)};
    in_warp   = {w1, w0};
    in_mask   = {mk(w1), mk(w0)};
    out_ready = ordy;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic       v0; logic [7:0] l0; logic [5:0] w0;
    logic       v1; logic [7:0] l1; logic [5:0] w1;
    logic       ordy;
    logic [1:0] erdy;
    logic       eov; logic [7:0] eline; logic [2:0] ecnt;
  } vec_t;

  // R2 R3 R4 R5 R6 R7 R10 R11 R12 sequence; outputs checked one edge later
  localparam vec_t VECS [9] = '{
    '{1'b1, 8'h10, 6'd1, 1'b0, 8'h00, 6'd0, 1'b0, 2'b01, 1'b1, 8'h10, 3'd1},
    '{1'b1, 8'h10, 6'd2, 1'b1, 8'h10, 6'd3, 1'b0, 2'b01, 1'b1, 8'h10, 3'd2},
    '{1'b0, 8'h00, 6'd0, 1'b1, 8'h10, 6'd3, 1'b0, 2'b10, 1'b1, 8'h10, 3'd3},
    '{1'b1, 8'h10, 6'd4, 1'b1, 8'h21, 6'd5, 1'b0, 2'b11, 1'b1, 8'h10, 3'd4},
    '{1'b1, 8'h10, 6'd6, 1'b0, 8'h00, 6'd0, 1'b0, 2'b01, 1'b1, 8'h10, 3'd4},
    '{1'b0, 8'h00, 6'd0, 1'b0, 8'h00, 6'd0, 1'b1, 2'b00, 1'b1, 8'h21, 3'd1},
    '{1'b1, 8'h01, 6'd7, 1'b0, 8'h00, 6'd0, 1'b1, 2'b00, 1'b1, 8'h10, 3'd1},
    '{1'b1, 8'h01, 6'd7, 1'b0, 8'h00, 6'd0, 1'b1, 2'b01, 1'b1, 8'h01, 3'd1},
    '{1'b0, 8'h00, 6'd0, 1'b0, 8'h00, 6'd0, 1'b1, 2'b00, 1'b0, 8'h00, 3'd0}
  };

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid in reset", out_valid, 0);
    chk("R1", "in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    step();
    chk("R1", "out_valid after reset", out_valid, 0);

    // vector table
    foreach (VECS[k]) begin
      drive(VECS[k].v0, VECS[k].l0, VECS[k].w0, VECS[k].v1, VECS[k].l1, VECS[k].w1, VECS[k].ordy);
      #1;
      chk("R6/R11/R12", $sformatf("vec %0d in_ready", k), in_ready, VECS[k].erdy);
      step();
      chk("R4/R5/R9/R10", $sformatf("vec %0d out_valid", k), out_valid, VECS[k].eov);
      chk("R4/R5/R9/R10", $sformatf("vec %0d out_line", k), out_line, LW'(VECS[k].eline));
      chk("R4/R5/R9/R10", $sformatf("vec %0d out_count", k), out_count, VECS[k].ecnt);
    end

    // R3 R4: sharer list order and unused slots zero
    drive(1, 8'h07, 6'd9, 0, 0, 0, 0);  step();
    drive(0, 0, 0, 1, 8'h07, 6'd10, 0); step();
    drive(1, 8'h07, 6'd11, 0, 0, 0, 0); step();
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R4", "sharer count", out_count, 3);
    chk("R4", "sharer warps in order", out_warps, {6'd0, 6'd11, 6'd10, 6'd9});
    chk("R3", "sharer masks, slot 3 zero", out_masks, {32'h0, mk(6'd11), mk(6'd10), mk(6'd9)});
    drive(0, 0, 0, 0, 0, 0, 1); step();
    chk("R10", "entry freed on handshake", out_valid, 0);

    // R7 R9: same-cycle allocations in two queues, lower entry index first
    drive(1, 8'h05, 6'd1, 1, 8'h02, 6'd2, 0);
    #1 chk("R7", "both inputs ready", in_ready, 2'b11);
    step();
    chk("R9", "tie goes to lower entry index", out_line, LW'(8'h02));
    drive(0, 0, 0, 0, 0, 0, 1); step();
    chk("R9", "second entry next", out_line, LW'(8'h05));
    step();
    chk("R10", "pool empty", out_valid, 0);

    // R8: full queue 3
    for (int k = 0; k < 4; k++) begin
      drive(1, 8'h03 + 8'(32*k), 6'(k), 0, 0, 0, 0);
      step();
    end
    drive(1, 8'h83, 6'd8, 0, 0, 0, 0);
    #1 chk("R8", "miss into full queue stalls", in_ready[0], 0);
    drive(1, 8'h23, 6'd9, 0, 0, 0, 0);
    #1 chk("R4", "hit into full queue accepted", in_ready[0], 1);
    drive(1, 8'h83, 6'd8, 0, 0, 0, 1);
    #1 chk("R11", "no insert while queue granted", in_ready[0], 0);
    step();
    chk("R9", "oldest after pop", out_line, LW'(8'h23));
    drive(1, 8'h83, 6'd8, 0, 0, 0, 0);
    #1 chk("R8", "freed slot accepts", in_ready[0], 1);
    step();
    drive(0, 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 16; k++) if (out_valid) step();
    chk("R10", "drained", out_valid, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule